// File: doc/BRIEF.md
# Single-Line Home Directory Controller

This block is the home node for one memory line that several caches share. It keeps the directory view of the line: a stable state (invalid, shared, exclusive, modified), a bit-vector of the caches that hold a shared copy, and the owning cache. It also keeps the memory copy of the data and the bookkeeping for the transaction in flight. It reacts to one inbound message at a time. A message is a read or write request, an invalidation ack, a coherence ack, a transfer ack, or a writeback with or without data. In response it emits invalidate, set-tag, set-tag-and-wakeup, transfer, writeback and data commands toward the caches.

Every message is offered for one or more cycles and is either consumed, with `in_accept` high in that cycle, or refused. A refused message is left with the sender to retry. The block refuses new requests while a transaction is open. It refuses message kinds that the current state does not expect. It refuses everything while commands from an earlier step are still draining.

A move of ownership takes three steps. The block first invalidates the old owner. It then tells the old owner to forward the line to the requester and to write it back. Finally it waits for the transfer ack. A write from a cache that already shares the line is handled as an upgrade: the other sharers are invalidated and the requester is woken up without being sent any data.

Top module: `dir_home`

## Requirements
- R1: After reset the directory state is invalid (code 0) and the sharer vector is empty. The owner-valid flag, `cmd_valid` and `ack_err` are low, and the memory copy holds `INIT_DATA`. State codes are: I=0, S=1, E=2, M=3, wait-inval-acks=4, wait-coh-ack=5, wait-writeback=6, wait-transfer-ack=7.
- R2: A read (message code 0) in state I is answered to the requester with a data command (op 5) carrying the memory copy, then a set-tag (op 1) with cache state E (2). The block then enters state 5 and records E as the pending home state.
- R3: A write (message code 1) in state I does the same as R2 with cache state M (3) and pending home state M.
- R4: A read in state S is answered with data, then a set-tag with cache state S (1). Its coherence ack adds the requester to the sharers, and the owner-valid flag stays low.
- R5: A write from a cache that is not a sharer, in state S, sends one invalidate (op 0) to every sharer in ascending index order and enters state 4. When the last invalidation ack (code 2) arrives, the block sends data, then a set-tag with cache state M, to the requester. Each ack clears its sender's sharer bit.
- R6: A write from a sharer, in state S, while other sharers exist, invalidates only the other sharers. After their acks the block sends one wakeup (op 2) with cache state M and no data, then enters state 5.
- R7: A write from the only sharer sends a wakeup at once and enters state 5 with no invalidations.
- R8: Any request in state E or M sends one invalidate to the owner. The owner's ack produces three commands in this order. First, a set-tag to the requester (S for a read, M for a write). Second, a transfer (op 3) to the old owner, with the requester as target. Third, a writeback (op 4) to the old owner. The block then enters state 6.
- R9: In state 6, a writeback with data (code 5) or a null writeback (code 6) stores its payload as the memory copy and moves the block to state 7. A transfer ack (code 4) arriving in state 6 is refused.
- R10: The final coherence ack (code 3) or transfer ack moves the block to the pending home state. For E or M the sharers are cleared and the requester becomes the valid owner. For S the requester is added to the sharers and the owner-valid flag is cleared.
- R11: Read and write requests offered in any of the states 4 to 7 are refused and change nothing.
- R12: A coherence ack or transfer ack from a cache other than the recorded requester is consumed. It sets the sticky `ack_err` flag and leaves the state unchanged.
- R13: A message kind that the current state does not expect is refused. Every message is refused while commands from an earlier step remain to be issued.
- R14: Commands leave one per cycle with `cmd_valid` high. The first command of a step appears on the second rising edge after the edge that consumed its message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound message offered |
| in_type | input | 3 | Message code (0 read, 1 write, 2 inval ack, 3 coh ack, 4 transfer ack, 5 writeback, 6 null writeback) |
| in_src | input | ID_W | Sending cache index |
| in_data | input | DATA_W | Writeback payload |
| in_accept | output | 1 | Message consumed this cycle |
| cmd_valid | output | 1 | Command valid |
| cmd_op | output | 3 | Command code (0 inval, 1 set-tag, 2 wakeup, 3 transfer, 4 writeback, 5 data) |
| cmd_dest | output | ID_W | Destination cache |
| cmd_target | output | ID_W | Transfer target cache |
| cmd_state | output | 2 | Cache state for set-tag or wakeup (0 I, 1 S, 2 E, 3 M) |
| cmd_data | output | DATA_W | Data payload |
| dir_state | output | 3 | Directory state code |
| dir_sharers | output | N | Sharer bit-vector |
| dir_owner | output | ID_W | Owning cache |
| dir_owner_vld | output | 1 | Owner field valid |
| ack_err | output | 1 | Sticky flag for an ack from the wrong cache |

## Verification
The main function is driven through every home state. The stimulus covers a first read from invalid, repeated reads that grow the sharer set, a write from a non-sharer against two sharers, and an upgrade against two others. It also covers an upgrade by the lone sharer, and both read and write ownership moves out of modified and exclusive. The non-sharer write and the upgrade differ only in whether a data command follows the acks, so comparing them shows that membership picks the path. The ownership moves check the exact set-tag, transfer, writeback order and target fields. A later read returns the written-back value, which shows the writeback really updated memory. Refusal cases cover requests during open transactions, an early transfer ack, an unexpected message kind and a message offered while commands drain. A wrong-source ack is also exercised.

// File: rtl/dir_home_pkg.sv
`timescale 1ns/1ps
package dir_home_pkg;
  typedef enum logic [2:0] {
    H_I = 3'd0, H_S = 3'd1, H_E = 3'd2, H_M = 3'd3,
    H_WINV = 3'd4, H_WCOH = 3'd5, H_WWB = 3'd6, H_WTR = 3'd7
  } hstate_e;

  localparam logic [2:0] M_RD      = 3'd0;
  localparam logic [2:0] M_WR      = 3'd1;
  localparam logic [2:0] M_INV_ACK = 3'd2;
  localparam logic [2:0] M_COH_ACK = 3'd3;
  localparam logic [2:0] M_TR_ACK  = 3'd4;
  localparam logic [2:0] M_WB_DATA = 3'd5;
  localparam logic [2:0] M_WB_NULL = 3'd6;

  localparam logic [2:0] C_INV       = 3'd0;
  localparam logic [2:0] C_SET_TAG   = 3'd1;
  localparam logic [2:0] C_WAKEUP    = 3'd2;
  localparam logic [2:0] C_TRANSFER  = 3'd3;
  localparam logic [2:0] C_WRITEBACK = 3'd4;
  localparam logic [2:0] C_DATA      = 3'd5;

  localparam logic [1:0] CS_I = 2'd0;
  localparam logic [1:0] CS_S = 2'd1;
  localparam logic [1:0] CS_E = 2'd2;
  localparam logic [1:0] CS_M = 2'd3;
endpackage

// File: rtl/dir_cmd_fifo.sv
`timescale 1ns/1ps
module dir_cmd_fifo #(
  parameter int W       = 16,
  parameter int DEPTH   = 4,
  parameter int MAXPUSH = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(MAXPUSH+1)-1:0] push_n,
  input  logic [MAXPUSH-1:0][W-1:0]   push_data,
  input  logic                        pop,
  output logic [W-1:0]                head,
  output logic                        empty
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CW     = PTR_W + 1;
  localparam int PCNT_W = $clog2(MAXPUSH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAXPUSH; k++) begin
      if (PCNT_W'(k) < push_n) mem[wr_ptr + PTR_W'(k)] <= push_data[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + CW'(push_n) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
endmodule

// File: rtl/dir_inv_scan.sv
`timescale 1ns/1ps
module dir_inv_scan #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [N-1:0]    load_mask,
  input  logic            take,
  output logic            any,
  output logic [ID_W-1:0] idx
);
  logic [N-1:0] pend;

  always_comb begin
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pend[i]) idx = ID_W'(i);
    end
  end

  assign any = |pend;

  always_ff @(posedge clk) begin
    if (rst)       pend <= '0;
    else if (load) pend <= load_mask;
    else if (take) pend <= pend & ~(N'(1) << idx);
  end
endmodule

// File: rtl/dir_home_fsm.sv
`timescale 1ns/1ps
module dir_home_fsm
  import dir_home_pkg::*;
#(
  parameter int          N         = 4,
  parameter int          ID_W      = 2,
  parameter int          DATA_W    = 8,
  parameter int          CMD_W     = 3 + 2*ID_W + 2 + DATA_W,
  parameter logic [DATA_W-1:0] INIT_DATA = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           in_type,
  input  logic [ID_W-1:0]      in_src,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 busy,
  output logic                 in_accept,
  output logic [1:0]           push_n,
  output logic [2:0][CMD_W-1:0] push_data,
  output logic                 inv_load,
  output logic [N-1:0]         inv_mask,
  output hstate_e              state,
  output logic [N-1:0]         sharers,
  output logic [ID_W-1:0]      owner,
  output logic                 owner_vld,
  output logic                 ack_err
);
  localparam int CNT_W = $clog2(N+1);

  logic [DATA_W-1:0] mem;
  logic [CNT_W-1:0]  ack_cnt;
  logic              upg, xfer;
  logic [ID_W-1:0]   req, trc;
  logic [1:0]        pcs;
  hstate_e           phs;

  hstate_e           n_state, n_phs;
  logic [N-1:0]      n_sharers;
  logic [ID_W-1:0]   n_owner, n_req, n_trc;
  logic              n_owner_vld, n_upg, n_xfer, err_set;
  logic [DATA_W-1:0] n_mem;
  logic [CNT_W-1:0]  n_ack, cnt;
  logic [1:0]        n_pcs;
  logic              legal, is_wr;
  logic [N-1:0]      src_bit;

  function automatic logic [CMD_W-1:0] pk(input logic [2:0] op, input logic [ID_W-1:0] d,
                                          input logic [ID_W-1:0] t, input logic [1:0] s,
                                          input logic [DATA_W-1:0] x);
    return {op, d, t, s, x};
  endfunction

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CNT_W'(sharers[i]);
  end

  assign src_bit = N'(1) << in_src;
  assign is_wr   = (in_type == M_WR);

  always_comb begin
    case (state)
      H_I, H_S, H_E, H_M: legal = (in_type == M_RD) || (in_type == M_WR);
      H_WINV:             legal = (in_type == M_INV_ACK);
      H_WCOH:             legal = (in_type == M_COH_ACK);
      H_WWB:              legal = (in_type == M_WB_DATA) || (in_type == M_WB_NULL);
      default:            legal = (in_type == M_TR_ACK);
    endcase
  end

  assign in_accept = in_valid && !busy && legal;

  always_comb begin
    n_state = state; n_phs = phs; n_sharers = sharers; n_owner = owner;
    n_owner_vld = owner_vld; n_req = req; n_trc = trc; n_upg = upg; n_xfer = xfer;
    n_mem = mem; n_ack = ack_cnt; n_pcs = pcs; err_set = 1'b0;
    push_n = 2'd0; push_data = '0; inv_load = 1'b0; inv_mask = '0;
    if (in_accept) begin
      case (state)
        H_I, H_S: begin
          n_req = in_src;
          n_xfer = 1'b0;
          if (state == H_I || !is_wr) begin
            n_upg = 1'b0;
            n_ack = '0;
            n_pcs = (state == H_S) ? CS_S : (is_wr ? CS_M : CS_E);
            n_phs = (state == H_S) ? H_S : (is_wr ? H_M : H_E);
            push_n = 2'd2;
            push_data[0] = pk(C_DATA, in_src, '0, CS_I, mem);
            push_data[1] = pk(C_SET_TAG, in_src, '0, n_pcs, '0);
            n_state = H_WCOH;
          end else begin
            n_pcs = CS_M;
            n_phs = H_M;
            inv_mask = sharers & ~src_bit;
            inv_load = |inv_mask;
            if (sharers[in_src]) begin
              n_upg = 1'b1;
              n_ack = cnt - CNT_W'(1);
              if (cnt == CNT_W'(1)) begin
                push_n = 2'd1;
                push_data[0] = pk(C_WAKEUP, in_src, '0, CS_M, '0);
                n_state = H_WCOH;
              end else begin
                n_state = H_WINV;
              end
            end else begin
              n_upg = 1'b0;
              n_ack = cnt;
              n_state = H_WINV;
            end
          end
        end
        H_E, H_M: begin
          inv_mask = N'(1) << owner;
          inv_load = 1'b1;
          n_ack = CNT_W'(1);
          n_xfer = 1'b1;
          n_upg = 1'b0;
          n_trc = owner;
          n_req = in_src;
          n_pcs = is_wr ? CS_M : CS_S;
          n_phs = is_wr ? H_M : H_S;
          n_state = H_WINV;
        end
        H_WINV: begin
          n_sharers = sharers & ~src_bit;
          n_ack = ack_cnt - CNT_W'(1);
          if (ack_cnt == CNT_W'(1)) begin
            if (upg) begin
              push_n = 2'd1;
              push_data[0] = pk(C_WAKEUP, req, '0, CS_M, '0);
              n_state = H_WCOH;
            end else if (xfer) begin
              push_n = 2'd3;
              push_data[0] = pk(C_SET_TAG, req, '0, pcs, '0);
              push_data[1] = pk(C_TRANSFER, trc, req, CS_I, '0);
              push_data[2] = pk(C_WRITEBACK, trc, '0, CS_I, '0);
              n_state = H_WWB;
            end else begin
              push_n = 2'd2;
              push_data[0] = pk(C_DATA, req, '0, CS_I, mem);
              push_data[1] = pk(C_SET_TAG, req, '0, pcs, '0);
              n_state = H_WCOH;
            end
          end
        end
        H_WWB: begin
          n_mem = in_data;
          n_state = H_WTR;
        end
        default: begin
          if (in_src != req) begin
            err_set = 1'b1;
          end else begin
            n_state = phs;
            n_xfer = 1'b0;
            if (phs == H_S) begin
              n_sharers = sharers | (N'(1) << req);
              n_owner_vld = 1'b0;
            end else begin
              n_sharers = '0;
              n_owner = req;
              n_owner_vld = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= H_I; phs <= H_I; sharers <= '0; owner <= '0; owner_vld <= 1'b0;
      req <= '0; trc <= '0; upg <= 1'b0; xfer <= 1'b0; mem <= INIT_DATA;
      ack_cnt <= '0; pcs <= CS_I; ack_err <= 1'b0;
    end else begin
      state <= n_state; phs <= n_phs; sharers <= n_sharers; owner <= n_owner;
      owner_vld <= n_owner_vld; req <= n_req; trc <= n_trc; upg <= n_upg;
      xfer <= n_xfer; mem <= n_mem; ack_cnt <= n_ack; pcs <= n_pcs;
      if (err_set) ack_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dir_home.sv
`timescale 1ns/1ps
module dir_home
  import dir_home_pkg::*;
#(
  parameter int          N         = 4,
  parameter int          DATA_W    = 8,
  parameter logic [DATA_W-1:0] INIT_DATA = 8'h11,
  parameter int          ID_W      = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [ID_W-1:0]   in_src,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_accept,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ID_W-1:0]   cmd_dest,
  output logic [ID_W-1:0]   cmd_target,
  output logic [1:0]        cmd_state,
  output logic [DATA_W-1:0] cmd_data,
  output logic [2:0]        dir_state,
  output logic [N-1:0]      dir_sharers,
  output logic [ID_W-1:0]   dir_owner,
  output logic              dir_owner_vld,
  output logic              ack_err
);
  localparam int CMD_W   = 3 + 2*ID_W + 2 + DATA_W;
  localparam int Q_DEPTH = 4;

  logic [1:0]            push_n;
  logic [2:0][CMD_W-1:0] push_data;
  logic                  inv_load, inv_any, q_empty, busy, q_pop;
  logic [N-1:0]          inv_mask;
  logic [ID_W-1:0]       inv_idx;
  logic [CMD_W-1:0]      q_head;
  hstate_e               core_state;

  assign busy  = inv_any || !q_empty;
  assign q_pop = !inv_any && !q_empty;

  dir_home_fsm #(.N(N), .ID_W(ID_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .INIT_DATA(INIT_DATA)) u_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type), .in_src(in_src),
    .in_data(in_data), .busy(busy), .in_accept(in_accept), .push_n(push_n),
    .push_data(push_data), .inv_load(inv_load), .inv_mask(inv_mask), .state(core_state),
    .sharers(dir_sharers), .owner(dir_owner), .owner_vld(dir_owner_vld), .ack_err(ack_err)
  );

  dir_inv_scan #(.N(N), .ID_W(ID_W)) u_scan (
    .clk(clk), .rst(rst), .load(inv_load), .load_mask(inv_mask), .take(inv_any),
    .any(inv_any), .idx(inv_idx)
  );

  dir_cmd_fifo #(.W(CMD_W), .DEPTH(Q_DEPTH), .MAXPUSH(3)) u_q (
    .clk(clk), .rst(rst), .push_n(push_n), .push_data(push_data), .pop(q_pop),
    .head(q_head), .empty(q_empty)
  );

  assign dir_state = core_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0; cmd_op <= '0; cmd_dest <= '0; cmd_target <= '0;
      cmd_state <= '0; cmd_data <= '0;
    end else if (inv_any) begin
      cmd_valid <= 1'b1; cmd_op <= C_INV; cmd_dest <= inv_idx; cmd_target <= '0;
      cmd_state <= CS_I; cmd_data <= '0;
    end else if (!q_empty) begin
      cmd_valid  <= 1'b1;
      cmd_op     <= q_head[CMD_W-1 -: 3];
      cmd_dest   <= q_head[CMD_W-4 -: ID_W];
      cmd_target <= q_head[CMD_W-4-ID_W -: ID_W];
      cmd_state  <= q_head[DATA_W+1 -: 2];
      cmd_data   <= q_head[DATA_W-1:0];
    end else begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dir_home_chk.sv
`timescale 1ns/1ps
module dir_home_chk
  import dir_home_pkg::*;
#(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [2:0]   in_type,
  input logic         in_accept,
  input logic         cmd_valid,
  input logic [2:0]   dir_state,
  input logic [N-1:0] dir_sharers,
  input logic         dir_owner_vld,
  input logic         ack_err
);
  p_invalid_clean_r1: assert property (@(posedge clk) disable iff (rst)
    dir_state == H_I |-> (dir_sharers == '0 && !dir_owner_vld));

  p_req_refused_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_type == M_RD || in_type == M_WR) && dir_state[2]) |-> !in_accept);

  p_early_tr_refused_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_type == M_TR_ACK && dir_state == H_WWB) |-> !in_accept);

  p_owned_no_sharers_r10: assert property (@(posedge clk) disable iff (rst)
    (dir_state == H_E || dir_state == H_M) |-> (dir_sharers == '0 && dir_owner_vld));

  p_shared_no_owner_r4: assert property (@(posedge clk) disable iff (rst)
    dir_state == H_S |-> !dir_owner_vld);

  p_cmd_latency_r14: assert property (@(posedge clk) disable iff (rst)
    (in_accept && (in_type == M_RD || in_type == M_WR)) |=> ##1 cmd_valid);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> ack_err);
endmodule

bind dir_home dir_home_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type), .in_accept(in_accept),
  .cmd_valid(cmd_valid), .dir_state(dir_state), .dir_sharers(dir_sharers),
  .dir_owner_vld(dir_owner_vld), .ack_err(ack_err)
);

// File: tb/dir_home_test.sv
`timescale 1ns/1ps
module dir_home_test;
  localparam int NV = 38;
  // message codes
  localparam logic [2:0] RD = 0, WR = 1, IA = 2, CO = 3, TA = 4, WB = 5, WN = 6;
  localparam logic [16:0] Z = '0;

  typedef struct packed {
    logic [3:0]       rq;
    logic [2:0]       mt;
    logic [1:0]       src;
    logic [7:0]       data;
    logic             acc;
    logic [2:0]       ncmd;
    logic [3:0][16:0] cmds;
    logic [2:0]       st;
    logic [3:0]       sh;
    logic             ov;
    logic [1:0]       own;
  } vec_t;

  // command word: op, dest, target, cache state, data
  function automatic logic [16:0] c(input logic [2:0] op, input logic [1:0] d, input logic [1:0] t,
                                    input logic [1:0] s, input logic [7:0] x);
    return {op, d, t, s, x};
  endfunction

  localparam vec_t VEC [NV] = '{
    '{4'd2,  RD, 2'd1, 8'h00, 1'b1, 3'd2, {c(5,1,0,0,8'h11), c(1,1,0,2,0), Z, Z}, 3'd5, 4'b0000, 1'b0, 2'd0}, // R2
    '{4'd11, RD, 2'd2, 8'h00, 1'b0, 3'd0, {Z, Z, Z, Z}, 3'd5, 4'b0000, 1'b0, 2'd0},                         // R11
    '{4'd12, CO, 2'd2, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd5, 4'b0000, 1'b0, 2'd0},                         // R12
    '{4'd2,  CO, 2'd1, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd2, 4'b0000, 1'b1, 2'd1},
    '{4'd8,  RD, 2'd0, 8'h00, 1'b1, 3'd1, {c(0,1,0,0,0), Z, Z, Z}, 3'd4, 4'b0000, 1'b1, 2'd1},              // R8
    '{4'd13, TA, 2'd0, 8'h00, 1'b0, 3'd0, {Z, Z, Z, Z}, 3'd4, 4'b0000, 1'b1, 2'd1},                         // R13
    '{4'd8,  IA, 2'd1, 8'h00, 1'b1, 3'd3, {c(1,0,0,1,0), c(3,1,0,0,0), c(4,1,0,0,0), Z}, 3'd6, 4'b0000, 1'b1, 2'd1},
    '{4'd9,  TA, 2'd0, 8'h00, 1'b0, 3'd0, {Z, Z, Z, Z}, 3'd6, 4'b0000, 1'b1, 2'd1},                         // R9
    '{4'd9,  WN, 2'd1, 8'h11, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd7, 4'b0000, 1'b1, 2'd1},
    '{4'd10, TA, 2'd0, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd1, 4'b0001, 1'b0, 2'd0},                         // R10
    '{4'd4,  RD, 2'd2, 8'h00, 1'b1, 3'd2, {c(5,2,0,0,8'h11), c(1,2,0,1,0), Z, Z}, 3'd5, 4'b0001, 1'b0, 2'd0}, // R4
    '{4'd4,  CO, 2'd2, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd1, 4'b0101, 1'b0, 2'd0},
    '{4'd4,  RD, 2'd3, 8'h00, 1'b1, 3'd2, {c(5,3,0,0,8'h11), c(1,3,0,1,0), Z, Z}, 3'd5, 4'b0101, 1'b0, 2'd0},
    '{4'd4,  CO, 2'd3, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd1, 4'b1101, 1'b0, 2'd0},
    '{4'd6,  WR, 2'd0, 8'h00, 1'b1, 3'd2, {c(0,2,0,0,0), c(0,3,0,0,0), Z, Z}, 3'd4, 4'b1101, 1'b0, 2'd0},   // R6
    '{4'd6,  IA, 2'd3, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd4, 4'b0101, 1'b0, 2'd0},
    '{4'd6,  IA, 2'd2, 8'h00, 1'b1, 3'd1, {c(2,0,0,3,0), Z, Z, Z}, 3'd5, 4'b0001, 1'b0, 2'd0},
    '{4'd6,  CO, 2'd0, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd3, 4'b0000, 1'b1, 2'd0},
    '{4'd8,  WR, 2'd2, 8'h00, 1'b1, 3'd1, {c(0,0,0,0,0), Z, Z, Z}, 3'd4, 4'b0000, 1'b1, 2'd0},
    '{4'd8,  IA, 2'd0, 8'h00, 1'b1, 3'd3, {c(1,2,0,3,0), c(3,0,2,0,0), c(4,0,0,0,0), Z}, 3'd6, 4'b0000, 1'b1, 2'd0},
    '{4'd9,  WB, 2'd0, 8'h5A, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd7, 4'b0000, 1'b1, 2'd0},
    '{4'd10, TA, 2'd2, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd3, 4'b0000, 1'b1, 2'd2},
    '{4'd8,  RD, 2'd1, 8'h00, 1'b1, 3'd1, {c(0,2,0,0,0), Z, Z, Z}, 3'd4, 4'b0000, 1'b1, 2'd2},
    '{4'd8,  IA, 2'd2, 8'h00, 1'b1, 3'd3, {c(1,1,0,1,0), c(3,2,1,0,0), c(4,2,0,0,0), Z}, 3'd6, 4'b0000, 1'b1, 2'd2},
    '{4'd9,  WB, 2'd2, 8'h77, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd7, 4'b0000, 1'b1, 2'd2},
    '{4'd10, TA, 2'd1, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd1, 4'b0010, 1'b0, 2'd0},
    '{4'd9,  RD, 2'd3, 8'h00, 1'b1, 3'd2, {c(5,3,0,0,8'h77), c(1,3,0,1,0), Z, Z}, 3'd5, 4'b0010, 1'b0, 2'd0},
    '{4'd4,  CO, 2'd3, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd1, 4'b1010, 1'b0, 2'd0},
    '{4'd5,  WR, 2'd0, 8'h00, 1'b1, 3'd2, {c(0,1,0,0,0), c(0,3,0,0,0), Z, Z}, 3'd4, 4'b1010, 1'b0, 2'd0},   // R5
    '{4'd5,  IA, 2'd1, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd4, 4'b1000, 1'b0, 2'd0},
    '{4'd5,  IA, 2'd3, 8'h00, 1'b1, 3'd2, {c(5,0,0,0,8'h77), c(1,0,0,3,0), Z, Z}, 3'd5, 4'b0000, 1'b0, 2'd0},
    '{4'd10, CO, 2'd0, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd3, 4'b0000, 1'b1, 2'd0},
    '{4'd8,  RD, 2'd1, 8'h00, 1'b1, 3'd1, {c(0,0,0,0,0), Z, Z, Z}, 3'd4, 4'b0000, 1'b1, 2'd0},
    '{4'd8,  IA, 2'd0, 8'h00, 1'b1, 3'd3, {c(1,1,0,1,0), c(3,0,1,0,0), c(4,0,0,0,0), Z}, 3'd6, 4'b0000, 1'b1, 2'd0},
    '{4'd9,  WN, 2'd0, 8'h33, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd7, 4'b0000, 1'b1, 2'd0},
    '{4'd10, TA, 2'd1, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd1, 4'b0010, 1'b0, 2'd0},
    '{4'd7,  WR, 2'd1, 8'h00, 1'b1, 3'd1, {c(2,1,0,3,0), Z, Z, Z}, 3'd5, 4'b0010, 1'b0, 2'd0},              // R7
    '{4'd7,  CO, 2'd1, 8'h00, 1'b1, 3'd0, {Z, Z, Z, Z}, 3'd3, 4'b0000, 1'b1, 2'd1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_type = '0;
  logic [1:0] in_src = '0;
  logic [7:0] in_data = '0;
  logic in_accept, cmd_valid, dir_owner_vld, ack_err;
  logic [2:0] cmd_op, dir_state;
  logic [1:0] cmd_dest, cmd_target, cmd_state, dir_owner;
  logic [7:0] cmd_data;
  logic [3:0] dir_sharers;

  int nchk = 0, nfail = 0, logn = 0;
  bit done = 1'b0;
  logic [16:0] log_q [8];

  always #4 clk = ~clk;

  dir_home #(.N(4), .DATA_W(8), .INIT_DATA(8'h11)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type), .in_src(in_src),
    .in_data(in_data), .in_accept(in_accept), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dest(cmd_dest), .cmd_target(cmd_target), .cmd_state(cmd_state), .cmd_data(cmd_data),
    .dir_state(dir_state), .dir_sharers(dir_sharers), .dir_owner(dir_owner),
    .dir_owner_vld(dir_owner_vld), .ack_err(ack_err)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      if (logn < 8) log_q[logn] = {cmd_op, cmd_dest, cmd_target, cmd_state, cmd_data};
      logn = logn + 1;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] mt, input logic [1:0] s, input logic [7:0] d, output logic acc);
    @(negedge clk);
    logn = 0;
    in_valid = 1'b1; in_type = mt; in_src = s; in_data = d;
    #1 acc = in_accept;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic acc;
    string r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk(dir_state == 3'd0 && dir_sharers == 4'd0 && !dir_owner_vld && !cmd_valid && !ack_err,
        "R1", {dir_state, dir_sharers, dir_owner_vld, cmd_valid, ack_err}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      r = $sformatf("R%0d vec%0d", VEC[v].rq, v);
      send(VEC[v].mt, VEC[v].src, VEC[v].data, acc);
      chk(acc == VEC[v].acc, {r, " accept"}, acc, VEC[v].acc);
      repeat (7) @(negedge clk);
      chk(logn == VEC[v].ncmd, {r, " count"}, logn, VEC[v].ncmd);
      for (int k = 0; k < 4; k++) begin
        if (k < VEC[v].ncmd && k < logn)
          chk(log_q[k] == VEC[v].cmds[3-k], {r, $sformatf(" cmd%0d", k)}, log_q[k], VEC[v].cmds[3-k]);
      end
      chk(dir_state == VEC[v].st && dir_sharers == VEC[v].sh && dir_owner_vld == VEC[v].ov,
          {r, " dir"}, {dir_state, dir_sharers, dir_owner_vld}, {VEC[v].st, VEC[v].sh, VEC[v].ov});
      if (VEC[v].ov) chk(dir_owner == VEC[v].own, {r, " owner"}, dir_owner, VEC[v].own);
    end

    // R12: flag raised by the wrong-source ack stays set
    chk(ack_err == 1'b1, "R12 sticky", ack_err, 1);

    // R1 again after a mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 chk(dir_state == 3'd0 && dir_sharers == 4'd0 && !dir_owner_vld && !ack_err && !cmd_valid,
           "R1 rereset", {dir_state, dir_sharers, dir_owner_vld, ack_err}, 0);

    // R3 + R14 + R13: write in I, command timing, refusal while draining
    @(negedge clk);
    in_valid = 1'b1; in_type = WR; in_src = 2'd3; in_data = 8'h00;
    #1 chk(in_accept == 1'b1, "R3 accept", in_accept, 1);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R14 no cmd one edge after accept", cmd_valid, 0);
    in_type = CO; in_src = 2'd3;
    #1 chk(in_accept == 1'b0, "R13 refused while draining", in_accept, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(cmd_valid && cmd_op == 3'd5 && cmd_dest == 2'd3 && cmd_data == 8'h11, "R14 first cmd data",
        {cmd_valid, cmd_op, cmd_dest, cmd_data}, {1'b1, 3'd5, 2'd3, 8'h11});
    @(negedge clk);
    chk(cmd_valid && cmd_op == 3'd1 && cmd_dest == 2'd3 && cmd_state == 2'd3, "R3 set-tag M",
        {cmd_valid, cmd_op, cmd_dest, cmd_state}, {1'b1, 3'd1, 2'd3, 2'd3});
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R14 stream ends", cmd_valid, 0);
    chk(dir_state == 3'd5, "R3 wait coh", dir_state, 5);
    send(CO, 2'd3, 8'h00, acc);
    chk(acc == 1'b1, "R3 coh accept", acc, 1);
    @(negedge clk);
    chk(dir_state == 3'd3 && dir_owner_vld && dir_owner == 2'd3 && dir_sharers == 4'd0, "R3 owner M",
        {dir_state, dir_owner_vld, dir_owner, dir_sharers}, {3'd3, 1'b1, 2'd3, 4'd0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule